// File: doc/BRIEF.md
# Hot-plug slot status register block

This block keeps the hot-insert and hot-remove bookkeeping for up to 32 slots on each of several buses and presents it to firmware as a small window of 32-bit registers. Slot events come in on dedicated inputs. A hot-plug event sets a pending-insert bit and a hot-unplug event sets a pending-remove bit. Either one raises a sticky notification level, which stays up until firmware acknowledges it on a separate clear input.

Firmware first writes a bus select register. It then reads that bus's pending-insert, pending-remove and removable masks. To retire a slot it writes the eject register: the lowest set bit of the written data names the slot. The block clears that slot's pending state and emits a one-cycle eject strobe carrying the bus and slot, unless the slot is not removable.

A flush sequence runs after the asynchronous reset and again on each `flush_i` pulse. It retires every pending removal on every bus, one slot per cycle. It then rebuilds each bus's removable mask from the per-slot fixed-device inputs.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset, `notify_o` is 0, `eject_o` is 0, the select register is 0 and all pending bits are 0. `busy_o` is 1 until the flush sequence ends (NUM_BUS cycles with nothing pending). The removable mask of bus b then reads as the inverse of `fixed_i[b*32 +: 32]`.
- R2: A `plug_valid_i` event with `plug_hot_i`=1 sets bit `plug_slot_i` of the pending-insert word of bus `plug_bus_i` and sets `notify_o`. With `plug_hot_i`=0 the event changes no bit and does not set `notify_o`.
- R3: An `unplug_valid_i` event sets bit `unplug_slot_i` of the pending-remove word of bus `unplug_bus_i` and sets `notify_o`.
- R4: `notify_o` holds at 1 until a cycle with `notify_clr_i`=1 and no new event. An event in the same cycle as the clear leaves it at 1.
- R5: A read of word offset 0x00 returns the selected bus's pending-insert word and clears that word, unless `legacy_i`=1. A plug event in the same cycle as the clearing read leaves its bit set.
- R6: Reads return the following: offset 0x04 gives pending-remove, 0x0C gives the removable mask, 0x10 gives the 32-bit select value, and 0x08 and any offset of 0x14 or more give 0. Read data appears on `rdata_o` with `rvalid_o`=1 in the cycle after the request.
- R7: An access is serviced only if `req_be_i`=4'hF and `req_addr_i[1:0]`=0. Any other access gives no `rvalid_o` and changes no state.
- R8: A write to 0x10 stores all 32 bits of data as the select value. While the select value is NUM_BUS or more, every read returns 0 (0x10 included), a read of 0x00 clears nothing, and eject writes do nothing.
- R9: An eject write (offset 0x08) with nonzero data takes the index of the lowest set bit as the slot. It clears that slot's pending-insert and pending-remove bits on the selected bus. Data 0 does nothing.
- R10: An eject makes `eject_o` 1 for one cycle, in the cycle after the write, with `eject_bus_o` and `eject_slot_o` set. This happens only if the slot's removable-mask bit is 1.
- R11: A flush (after reset or on `flush_i` while idle) visits buses in ascending order. On each bus it ejects the pending removals lowest slot first, one per cycle, and moves to the next bus one cycle after the current bus is empty. After the last bus it loads every removable mask and drops `busy_o`. Eject writes are ignored while `busy_o`=1.
- R12: Writes to offsets 0x00, 0x04 and 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte offset in the window |
| req_be_i | input | 4 | Byte enables; must be all ones to be serviced |
| req_wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| legacy_i | input | 1 | Keep pending-insert bits on read |
| plug_valid_i | input | 1 | Insert event |
| plug_hot_i | input | 1 | Event is a hot insert (0 = present at boot) |
| plug_bus_i | input | 2 | Bus of insert event |
| plug_slot_i | input | 5 | Slot of insert event |
| unplug_valid_i | input | 1 | Remove request event |
| unplug_bus_i | input | 2 | Bus of remove event |
| unplug_slot_i | input | 5 | Slot of remove event |
| fixed_i | input | 128 | Per bus and slot: device is fixed, not removable |
| flush_i | input | 1 | Start the flush sequence |
| busy_o | output | 1 | Flush sequence running |
| notify_o | output | 1 | Sticky firmware notification |
| notify_clr_i | input | 1 | Acknowledge notification |
| eject_o | output | 1 | Eject strobe |
| eject_bus_o | output | 2 | Bus of eject |
| eject_slot_o | output | 5 | Slot of eject |

## Verification
Every result is due one clock after its cause: read data, read-clear, eject strobes, select updates, pending bits and the notification. A flush takes one cycle per pending slot plus one per bus. The bench keeps a behavioural model that advances once per clock from the same inputs. It samples the outputs 1 ns after each rising edge and compares them with the model's prediction for that edge. Directed reads check explicit expected words, covering the corner cases: same-cycle event and clear, legacy mode, out-of-range select, malformed accesses and fixed slots.

// File: rtl/hp_pkg.sv
package hp_pkg;
  // word index = byte offset / 4
  typedef enum logic [2:0] {
    W_INS = 3'd0,
    W_REM = 3'd1,
    W_EJ  = 3'd2,
    W_RMV = 3'd3,
    W_SEL = 3'd4
  } word_e;
endpackage

// File: rtl/hp_lsb_enc.sv
module hp_lsb_enc #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/hp_bus_status.sv
module hp_bus_status #(
  parameter int NUM_SLOT = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SLOT-1:0] ins_set_i,
  input  logic [NUM_SLOT-1:0] rem_set_i,
  input  logic [NUM_SLOT-1:0] slot_clr_i,
  input  logic                ins_rdclr_i,
  input  logic                mask_ld_i,
  input  logic [NUM_SLOT-1:0] mask_val_i,
  output logic [NUM_SLOT-1:0] ins_o,
  output logic [NUM_SLOT-1:0] rem_o,
  output logic [NUM_SLOT-1:0] mask_o
);
  logic [NUM_SLOT-1:0] ins_q, rem_q, mask_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q  <= '0;
      rem_q  <= '0;
      mask_q <= '1;
    end else begin
      ins_q <= (ins_q & ~(slot_clr_i | {NUM_SLOT{ins_rdclr_i}})) | ins_set_i;
      rem_q <= (rem_q & ~slot_clr_i) | rem_set_i;
      if (mask_ld_i) mask_q <= mask_val_i;
    end
  end

  assign ins_o  = ins_q;
  assign rem_o  = rem_q;
  assign mask_o = mask_q;

  p_rdclr_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_rdclr_i && ins_set_i == '0 && slot_clr_i == '0) |=> ins_q == '0);

  p_event_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_rdclr_i |=> (ins_q & $past(ins_set_i)) == $past(ins_set_i));

  p_rem_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_set_i != '0) |=> (rem_q & $past(rem_set_i)) == $past(rem_set_i));
endmodule

// File: rtl/hp_flush_seq.sv
module hp_flush_seq #(
  parameter int NUM_BUS = 4,
  parameter int BW      = $clog2(NUM_BUS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [NUM_BUS-1:0] pend_i,
  output logic               busy_o,
  output logic [BW-1:0]      bus_o,
  output logic               ej_req_o,
  output logic               mask_ld_o
);
  localparam logic [BW-1:0] LAST = BW'(NUM_BUS - 1);

  logic          busy_q;
  logic [BW-1:0] bus_q;
  logic          cur_pend;

  assign cur_pend  = pend_i[bus_q];
  assign ej_req_o  = busy_q && cur_pend;
  assign mask_ld_o = busy_q && !cur_pend && (bus_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      bus_q  <= '0;
    end else if (busy_q) begin
      if (!cur_pend) begin
        if (bus_q == LAST) begin
          busy_q <= 1'b0;
          bus_q  <= '0;
        end else begin
          bus_q <= bus_q + 1'b1;
        end
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      bus_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign bus_o  = bus_q;

  p_done_after_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_ld_o |=> !busy_o);

  p_busy_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mask_ld_o) |=> busy_o);
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs #(
  parameter int NUM_BUS  = 4,
  parameter int NUM_SLOT = 32,
  parameter int ADDR_W   = 5,
  parameter int BUS_W    = $clog2(NUM_BUS),
  parameter int SLOT_W   = $clog2(NUM_SLOT)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic                        req_write_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [3:0]                  req_be_i,
  input  logic [31:0]                 req_wdata_i,
  output logic                        rvalid_o,
  output logic [31:0]                 rdata_o,
  input  logic                        legacy_i,
  input  logic                        plug_valid_i,
  input  logic                        plug_hot_i,
  input  logic [BUS_W-1:0]            plug_bus_i,
  input  logic [SLOT_W-1:0]           plug_slot_i,
  input  logic                        unplug_valid_i,
  input  logic [BUS_W-1:0]            unplug_bus_i,
  input  logic [SLOT_W-1:0]           unplug_slot_i,
  input  logic [NUM_BUS*NUM_SLOT-1:0] fixed_i,
  input  logic                        flush_i,
  output logic                        busy_o,
  output logic                        notify_o,
  input  logic                        notify_clr_i,
  output logic                        eject_o,
  output logic [BUS_W-1:0]            eject_bus_o,
  output logic [SLOT_W-1:0]           eject_slot_o
);
  import hp_pkg::*;

  localparam int DW = 32;
  localparam int WW = ADDR_W - 2;

  // access decode
  logic          acc_ok, rd, wr;
  logic [WW-1:0] word;
  assign acc_ok = req_valid_i && (req_be_i == 4'hF) && (req_addr_i[1:0] == 2'b00);
  assign rd     = acc_ok && !req_write_i;
  assign wr     = acc_ok && req_write_i;
  assign word   = req_addr_i[ADDR_W-1:2];

  logic [DW-1:0]    sel_q;
  logic             sel_ok;
  logic [BUS_W-1:0] sel_bus;
  assign sel_ok  = sel_q < DW'(NUM_BUS);
  assign sel_bus = sel_q[BUS_W-1:0];

  logic [NUM_SLOT-1:0] ins_w  [NUM_BUS];
  logic [NUM_SLOT-1:0] rem_w  [NUM_BUS];
  logic [NUM_SLOT-1:0] mask_w [NUM_BUS];
  logic [NUM_BUS-1:0]  rem_any;

  // flush sequencer
  logic             fl_busy, fl_ej, fl_mask_ld;
  logic [BUS_W-1:0] fl_bus;

  hp_flush_seq #(.NUM_BUS(NUM_BUS), .BW(BUS_W)) u_flush (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (flush_i),
    .pend_i    (rem_any),
    .busy_o    (fl_busy),
    .bus_o     (fl_bus),
    .ej_req_o  (fl_ej),
    .mask_ld_o (fl_mask_ld)
  );

  logic [SLOT_W-1:0] fl_slot, host_slot;
  logic              fl_any, host_any;

  hp_lsb_enc #(.W(NUM_SLOT), .IW(SLOT_W)) u_fl_enc (
    .vec_i (rem_w[fl_bus]),
    .idx_o (fl_slot),
    .any_o (fl_any)
  );

  hp_lsb_enc #(.W(NUM_SLOT), .IW(SLOT_W)) u_host_enc (
    .vec_i (req_wdata_i[NUM_SLOT-1:0]),
    .idx_o (host_slot),
    .any_o (host_any)
  );

  // eject source: flush wins, host ejects blocked while busy
  logic              host_ej, ej_fire;
  logic [BUS_W-1:0]  ej_bus;
  logic [SLOT_W-1:0] ej_slot;
  assign host_ej = wr && (word == WW'(W_EJ)) && sel_ok && !fl_busy && host_any;
  assign ej_fire = (fl_ej && fl_any) || host_ej;
  assign ej_bus  = fl_busy ? fl_bus  : sel_bus;
  assign ej_slot = fl_busy ? fl_slot : host_slot;

  logic ins_evt, rem_evt;
  assign ins_evt = plug_valid_i && plug_hot_i;
  assign rem_evt = unplug_valid_i;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic [NUM_SLOT-1:0] ins_set, rem_set, clr;
    logic                rdclr;
    assign ins_set = (ins_evt && plug_bus_i == BUS_W'(b))   ? NUM_SLOT'(1) << plug_slot_i   : '0;
    assign rem_set = (rem_evt && unplug_bus_i == BUS_W'(b)) ? NUM_SLOT'(1) << unplug_slot_i : '0;
    assign clr     = (ej_fire && ej_bus == BUS_W'(b))       ? NUM_SLOT'(1) << ej_slot       : '0;
    assign rdclr   = rd && (word == WW'(W_INS)) && sel_ok && (sel_bus == BUS_W'(b)) && !legacy_i;

    hp_bus_status #(.NUM_SLOT(NUM_SLOT)) u_stat (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ins_set_i   (ins_set),
      .rem_set_i   (rem_set),
      .slot_clr_i  (clr),
      .ins_rdclr_i (rdclr),
      .mask_ld_i   (fl_mask_ld),
      .mask_val_i  (~fixed_i[b*NUM_SLOT +: NUM_SLOT]),
      .ins_o       (ins_w[b]),
      .rem_o       (rem_w[b]),
      .mask_o      (mask_w[b])
    );
    assign rem_any[b] = |rem_w[b];
  end

  // read mux
  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (sel_ok) begin
      case (word)
        WW'(W_INS): rd_val = DW'(ins_w[sel_bus]);
        WW'(W_REM): rd_val = DW'(rem_w[sel_bus]);
        WW'(W_RMV): rd_val = DW'(mask_w[sel_bus]);
        WW'(W_SEL): rd_val = sel_q;
        default:    rd_val = '0;
      endcase
    end
  end

  logic              rvalid_q, notify_q, eject_q;
  logic [DW-1:0]     rdata_q;
  logic [BUS_W-1:0]  ej_bus_q;
  logic [SLOT_W-1:0] ej_slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
      sel_q     <= '0;
      notify_q  <= 1'b0;
      eject_q   <= 1'b0;
      ej_bus_q  <= '0;
      ej_slot_q <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_val;
      if (wr && word == WW'(W_SEL)) sel_q <= req_wdata_i;
      if (ins_evt || rem_evt)  notify_q <= 1'b1;
      else if (notify_clr_i)   notify_q <= 1'b0;
      eject_q <= ej_fire && mask_w[ej_bus][ej_slot];
      if (ej_fire) begin
        ej_bus_q  <= ej_bus;
        ej_slot_q <= ej_slot;
      end
    end
  end

  assign rvalid_o     = rvalid_q;
  assign rdata_o      = rdata_q;
  assign notify_o     = notify_q;
  assign eject_o      = eject_q;
  assign eject_bus_o  = ej_bus_q;
  assign eject_slot_o = ej_slot_q;
  assign busy_o       = fl_busy;

  p_notify_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_o && !notify_clr_i) |=> notify_o);

  p_boot_plug_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!notify_o && plug_valid_i && !plug_hot_i && !unplug_valid_i) |=> !notify_o);

  p_oob_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !sel_ok) |=> (rvalid_o && rdata_o == '0));

  p_oob_no_eject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !sel_ok) |=> !eject_o);

  p_bad_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_be_i != 4'hF) |=> !rvalid_o);
endmodule

// File: tb/hp_slot_regs_test.sv
module hp_slot_regs_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 0, req_write_i = 0;
  logic [4:0]   req_addr_i = '0;
  logic [3:0]   req_be_i = 4'hF;
  logic [31:0]  req_wdata_i = '0;
  logic         rvalid_o;
  logic [31:0]  rdata_o;
  logic         legacy_i = 0;
  logic         plug_valid_i = 0, plug_hot_i = 0;
  logic [1:0]   plug_bus_i = '0;
  logic [4:0]   plug_slot_i = '0;
  logic         unplug_valid_i = 0;
  logic [1:0]   unplug_bus_i = '0;
  logic [4:0]   unplug_slot_i = '0;
  logic [127:0] fixed_i;
  logic         flush_i = 0, busy_o, notify_o, notify_clr_i = 0, eject_o;
  logic [1:0]   eject_bus_o;
  logic [4:0]   eject_slot_o;

  hp_slot_regs uut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int cycles = 0;

  // reference model state
  logic [31:0] m_ins[4], m_rem[4], m_mask[4];
  logic [31:0] m_sel;
  logic        m_notify, m_busy;
  int          m_fbus;
  logic        e_rvalid, e_ej;
  logic [31:0] e_rdata;
  int          e_ejbus, e_ejslot;

  function automatic int lowbit(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_ins[b] = '0; m_rem[b] = '0; m_mask[b] = '1;
    end
    m_sel = '0; m_notify = 0; m_busy = 1; m_fbus = 0;
    e_rvalid = 0; e_ej = 0;
  endtask

  task automatic model_step();
    logic [31:0] n_ins[4], n_rem[4], n_mask[4];
    logic ok, rd, wr, inr;
    int   wd, ejb, ejs;
    logic ej;
    for (int b = 0; b < 4; b++) begin
      n_ins[b] = m_ins[b]; n_rem[b] = m_rem[b]; n_mask[b] = m_mask[b];
    end
    ok  = req_valid_i && req_be_i == 4'hF && req_addr_i[1:0] == 0;
    rd  = ok && !req_write_i;
    wr  = ok && req_write_i;
    wd  = int'(req_addr_i) / 4;
    inr = m_sel < 4;
    e_rvalid = rd;
    e_rdata  = '0;
    if (rd && inr) begin
      if (wd == 0) e_rdata = m_ins[m_sel];
      else if (wd == 1) e_rdata = m_rem[m_sel];
      else if (wd == 3) e_rdata = m_mask[m_sel];
      else if (wd == 4) e_rdata = m_sel;
      if (wd == 0 && !legacy_i) n_ins[m_sel] = '0;
    end
    ej = 0; ejb = 0; ejs = 0;
    if (m_busy) begin
      if (m_rem[m_fbus] != 0) begin
        ej = 1; ejb = m_fbus; ejs = lowbit(m_rem[m_fbus]);
      end else if (m_fbus == 3) begin
        for (int b = 0; b < 4; b++) n_mask[b] = ~fixed_i[b*32 +: 32];
      end
    end else if (wr && wd == 2 && inr && req_wdata_i != 0) begin
      ej = 1; ejb = int'(m_sel); ejs = lowbit(req_wdata_i);
    end
    if (ej) begin
      n_ins[ejb][ejs] = 1'b0;
      n_rem[ejb][ejs] = 1'b0;
      e_ejbus = ejb; e_ejslot = ejs;
    end
    e_ej = ej && m_mask[ejb][ejs];
    if (plug_valid_i && plug_hot_i) n_ins[plug_bus_i][plug_slot_i] = 1'b1;
    if (unplug_valid_i) n_rem[unplug_bus_i][unplug_slot_i] = 1'b1;
    if ((plug_valid_i && plug_hot_i) || unplug_valid_i) m_notify = 1;
    else if (notify_clr_i) m_notify = 0;
    if (m_busy) begin
      if (m_rem[m_fbus] == 0) begin
        if (m_fbus == 3) begin m_busy = 0; m_fbus = 0; end
        else m_fbus++;
      end
    end else if (flush_i) begin
      m_busy = 1; m_fbus = 0;
    end
    if (wr && wd == 4) m_sel = req_wdata_i;
    for (int b = 0; b < 4; b++) begin
      m_ins[b] = n_ins[b]; m_rem[b] = n_rem[b]; m_mask[b] = n_mask[b];
    end
  endtask

  // one clock: predict, clock, compare
  task automatic cyc();
    model_step();
    @(posedge clk_i);
    #1;
    chk("R6 rvalid", 32'(rvalid_o), 32'(e_rvalid));
    if (e_rvalid) chk("R6 rdata", rdata_o, e_rdata);
    chk("R4 notify", 32'(notify_o), 32'(m_notify));
    chk("R10 eject", 32'(eject_o), 32'(e_ej));
    if (e_ej) begin
      chk("R10 eject_bus", 32'(eject_bus_o), 32'(e_ejbus));
      chk("R10 eject_slot", 32'(eject_slot_o), 32'(e_ejslot));
    end
    chk("R11 busy", 32'(busy_o), 32'(m_busy));
    @(negedge clk_i);
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    cyc();
    d = rdata_o;
    req_valid_i = 0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    cyc();
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic plug(input int b, input int s, input logic hot);
    plug_valid_i = 1; plug_hot_i = hot; plug_bus_i = 2'(b); plug_slot_i = 5'(s);
    cyc();
    plug_valid_i = 0;
  endtask

  task automatic unplug(input int b, input int s);
    unplug_valid_i = 1; unplug_bus_i = 2'(b); unplug_slot_i = 5'(s);
    cyc();
    unplug_valid_i = 0;
  endtask

  task automatic clr_notify();
    notify_clr_i = 1; cyc(); notify_clr_i = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected done", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    fixed_i = '0;
    fixed_i[0*32 + 3]  = 1'b1;
    fixed_i[2*32 + 31] = 1'b1;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state and startup flush
    chk("R1 notify at reset", 32'(notify_o), 0);
    chk("R1 eject at reset", 32'(eject_o), 0);
    chk("R1 busy at reset", 32'(busy_o), 1);
    while (m_busy) cyc();
    rd_reg(5'h0C, d); chk("R1 mask bus0", d, ~32'h8);
    rd_reg(5'h10, d); chk("R1 select zero", d, 0);
    rd_reg(5'h00, d); chk("R1 insert zero", d, 0);

    // R2/R5: hot plug, read, read-clear
    plug(0, 5, 1);
    chk("R2 notify after plug", 32'(notify_o), 1);
    rd_reg(5'h00, d); chk("R5 insert read", d, 32'h20);
    rd_reg(5'h00, d); chk("R5 insert cleared", d, 0);
    clr_notify();
    chk("R4 notify cleared", 32'(notify_o), 0);
    plug(0, 6, 0);
    chk("R2 boot plug no notify", 32'(notify_o), 0);
    rd_reg(5'h00, d); chk("R2 boot plug no bit", d, 0);

    // R5: legacy keeps bits
    plug(0, 7, 1);
    legacy_i = 1;
    rd_reg(5'h00, d); chk("R5 legacy read1", d, 32'h80);
    rd_reg(5'h00, d); chk("R5 legacy read2", d, 32'h80);
    legacy_i = 0;
    rd_reg(5'h00, d); chk("R5 nonlegacy read", d, 32'h80);

    // R5: same-cycle event beats read-clear
    plug(0, 8, 1);
    plug_valid_i = 1; plug_hot_i = 1; plug_bus_i = 0; plug_slot_i = 9;
    rd_reg(5'h00, d);
    plug_valid_i = 0;
    chk("R5 read during plug", d, 32'h100);
    rd_reg(5'h00, d); chk("R5 event survives clear", d, 32'h200);

    // R4: event wins over clear
    notify_clr_i = 1; unplug(1, 2); notify_clr_i = 0;
    chk("R4 set wins over clear", 32'(notify_o), 1);

    // R3/R6: remove word and other offsets
    unplug(1, 4);
    wr_reg(5'h10, 32'd1);
    rd_reg(5'h04, d); chk("R3 remove word", d, 32'h14);
    rd_reg(5'h10, d); chk("R6 select read", d, 1);
    rd_reg(5'h08, d); chk("R6 eject reads zero", d, 0);
    rd_reg(5'h14, d); chk("R6 past window zero", d, 0);

    // R9/R10: eject lowest bit
    wr_reg(5'h08, 32'h1C);
    chk("R10 eject strobe", 32'(eject_o), 1);
    chk("R10 eject slot", 32'(eject_slot_o), 2);
    rd_reg(5'h04, d); chk("R9 remove after eject", d, 32'h10);
    wr_reg(5'h08, 32'h0);
    chk("R9 zero eject idle", 32'(eject_o), 0);

    // R7: malformed accesses
    req_be_i = 4'h3;
    rd_reg(5'h04, d);
    chk("R7 partial read no rvalid", 32'(rvalid_o), 0);
    wr_reg(5'h10, 32'd2);
    req_be_i = 4'hF;
    req_valid_i = 1; req_write_i = 1; req_addr_i = 5'h11; req_wdata_i = 32'd3;
    cyc(); req_valid_i = 0; req_write_i = 0;
    rd_reg(5'h10, d); chk("R7 select unchanged", d, 1);

    // R12: writes to status words ignored
    wr_reg(5'h04, '1);
    wr_reg(5'h0C, '0);
    wr_reg(5'h00, '1);
    rd_reg(5'h04, d); chk("R12 remove unchanged", d, 32'h10);
    rd_reg(5'h0C, d); chk("R12 mask unchanged", d, '1);
    rd_reg(5'h00, d); chk("R12 insert unchanged", d, 0);

    // R8: out-of-range select
    plug(1, 0, 1);
    wr_reg(5'h10, 32'h104);
    rd_reg(5'h10, d); chk("R8 select read zero", d, 0);
    rd_reg(5'h04, d); chk("R8 remove read zero", d, 0);
    rd_reg(5'h00, d); chk("R8 insert read zero", d, 0);
    wr_reg(5'h08, 32'h10);
    chk("R8 eject ignored", 32'(eject_o), 0);
    wr_reg(5'h10, 32'd1);
    rd_reg(5'h04, d); chk("R8 remove kept", d, 32'h10);
    rd_reg(5'h00, d); chk("R8 insert not cleared", d, 32'h1);

    // R10: non-removable slot ejects silently
    wr_reg(5'h10, 32'd0);
    unplug(0, 3);
    wr_reg(5'h08, 32'h8);
    chk("R10 fixed slot no strobe", 32'(eject_o), 0);
    rd_reg(5'h04, d); chk("R9 fixed slot cleared", d, 0);

    // R11: flush sequence
    unplug(0, 1); unplug(2, 0); unplug(2, 31); unplug(3, 10);
    flush_i = 1; cyc(); flush_i = 0;
    chk("R11 busy during flush", 32'(busy_o), 1);
    wr_reg(5'h10, 32'd1);
    wr_reg(5'h08, 32'h10);
    while (m_busy) cyc();
    for (int b = 0; b < 4; b++) begin
      wr_reg(5'h10, 32'(b));
      rd_reg(5'h04, d); chk("R11 remove flushed", d, 0);
    end
    rd_reg(5'h0C, d); chk("R11 mask bus3", d, '1);
    wr_reg(5'h10, 32'd2);
    rd_reg(5'h0C, d); chk("R11 mask bus2", d, 32'h7FFFFFFF);

    repeat (3) cyc();
    finish_run();
  end
endmodule